// File: doc/BRIEF.md
# Configurable Two-Table Logic Slice

This block models one programmable logic slice. It holds two 16-entry truth tables and a control word, all loaded through a small write port. A static mode field in the control word picks one of four behaviours. The slice can act as two 4-input functions, or as one 5-input function through a wide multiplexer. It can act as a 2-bit ripple unit that adds, subtracts, counts or compares, and it can be chained to a neighbour through its carry pins. It can also act as a 16x2 single-port RAM that writes on the clock edge and reads at once, or as two fixed 16x1 look-up tables.

Two output flip-flops can capture the combinational results or the multipurpose inputs. They share a clock enable and a synchronous local set/reset, and each flip-flop has its own configurable load value. The parameter `HAS_RAM` builds the RAM-less variant. In that variant, selecting RAM mode silences the data outputs and raises an error flag.

Top module: `logic_slice`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_wdata` on the next rising edge. Address 0 loads table 0, address 1 loads table 1, address 2 loads the control word from bits [8:0], and address 3 changes nothing. The control word fields are: [1:0] mode (0 logic, 1 ripple, 2 RAM, 3 ROM), [4:2] ripple operation, [5] load value of register 0, [6] load value of register 1, [7] source of register 0 (0 means `f0`, 1 means `m0`), and [8] source of register 1 (0 means `f1`, 1 means `m1`).
- R2: In logic mode, `f0` equals bit `in0` of table 0 and `f1` equals bit `in1` of table 1. The index is the 4-bit input value.
- R3: In logic mode, `ofx` equals `f1` when `m0` is 1 and `f0` when `m0` is 0. In every other mode `ofx` is 0.
- R4: In ripple mode, the operands are A = {in1[0], in0[0]} and B = {in1[1], in0[1]}. Operation 0 gives {cout,f1,f0} = A+B+cin. Operation 1 gives A+~B+cin. Operation 2 subtracts when `m0` is 1 and adds when `m0` is 0. Outside ripple mode `cout` is 0.
- R5: Operation 3 counts up: it gives {q1,q0}+cin. Operation 4 counts down: it gives {q1,q0}+3+cin, so it decrements when `cin` is 0. `cout` is 1 when there is no borrow. With register sources set to `f`, the registers step by one on each enabled edge.
- R6: Operation 5 (A>=B) and operation 7 (A<=B) form A+~B+cin and B+~A+cin respectively. Both drive `f0` and `cout` with the final carry. Operation 6 (not equal) drives `f0` and `cout` with cin OR (A!=B). For all three comparisons `f1` is 0.
- R7: In RAM mode, `in0` addresses both tables for reading, and the reads appear at once. When `ce` is 1 at a rising edge, `m0` is written to table 0 and `m1` to table 1 at that address. `in1` is ignored.
- R8: In ROM mode, the tables change only through the write port, whatever the values of `ce`, `m0` and `m1`.
- R9: With `HAS_RAM`=0 and RAM mode selected, `f0`, `f1`, `ofx` and `cout` are 0, `cfg_err` is 1, and no table write takes place.
- R10: With `lsr` high at a rising edge, each register loads its configured load value. This takes priority over `ce`.
- R11: With `lsr` low and `ce` low, both registers hold. With `ce` high, each register loads its selected source.
- R12: After reset, the tables, the control word and both registers are 0, so all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word select |
| cfg_wdata | input | 16 | Configuration write data |
| in0 | input | 4 | Inputs of table 0; RAM address |
| in1 | input | 4 | Inputs of table 1 |
| m0 | input | 1 | Multipurpose input 0: wide-mux select, add/sub control, RAM data bit 0, register data |
| m1 | input | 1 | Multipurpose input 1: RAM data bit 1, register data |
| ce | input | 1 | Clock enable; RAM write enable |
| lsr | input | 1 | Synchronous local set/reset |
| cin | input | 1 | Carry input from the neighbour slice |
| f0 | output | 1 | Combinational result 0 |
| f1 | output | 1 | Combinational result 1 |
| ofx | output | 1 | Wide multiplexer output |
| q0 | output | 1 | Register output 0 |
| q1 | output | 1 | Register output 1 |
| cout | output | 1 | Carry output to the neighbour slice |
| cfg_err | output | 1 | RAM mode selected in the RAM-less variant |

## Verification
The bench builds two slices side by side on the same inputs: one with `HAS_RAM`=1 and one with `HAS_RAM`=0. The first instance reaches the RAM write and asynchronous read path. The second reaches the error flag and the suppressed write. Switching both instances to ROM mode after the same RAM stimulus then shows, through `f0`, that only the first instance's table changed.

// File: rtl/slice_pkg.sv
package slice_pkg;

    localparam int LUT_K     = 4;
    localparam int LUT_DEPTH = 1 << LUT_K;
    localparam int ARITH_W   = 2;
    localparam int CFG_W     = LUT_DEPTH;

    typedef enum logic [1:0] {
        MODE_LOGIC  = 2'd0,
        MODE_RIPPLE = 2'd1,
        MODE_RAM    = 2'd2,
        MODE_ROM    = 2'd3
    } slice_mode_e;

    typedef enum logic [2:0] {
        OP_ADD    = 3'd0,
        OP_SUB    = 3'd1,
        OP_ADDSUB = 3'd2,
        OP_UP     = 3'd3,
        OP_DOWN   = 3'd4,
        OP_GE     = 3'd5,
        OP_NE     = 3'd6,
        OP_LE     = 3'd7
    } ripple_op_e;

    typedef struct packed {
        logic        src1;
        logic        src0;
        logic        init1;
        logic        init0;
        ripple_op_e  op;
        slice_mode_e mode;
    } slice_ctrl_t;

    localparam int CTRL_W = $bits(slice_ctrl_t);

    typedef struct packed {
        logic [LUT_DEPTH-1:0] tab1;
        logic [LUT_DEPTH-1:0] tab0;
        slice_ctrl_t          ctrl;
        logic                 q1;
        logic                 q0;
    } slice_state_t;

endpackage

// File: rtl/slice_lut.sv
module slice_lut #(
    parameter int K = 4,
    localparam int DEPTH = 1 << K
) (
    input  logic [DEPTH-1:0] tab,
    input  logic [K-1:0]     sel,
    output logic             y
);

    // binary mux tree, one level per select bit
    logic [DEPTH-1:0] lvl [K+1];

    assign lvl[0] = tab;

    for (genvar s = 0; s < K; s++) begin : g_level
        localparam int N = DEPTH >> (s + 1);
        always_comb begin
            lvl[s+1] = '0;
            for (int i = 0; i < N; i++) begin
                lvl[s+1][i] = sel[s] ? lvl[s][2*i+1] : lvl[s][2*i];
            end
        end
    end

    assign y = lvl[K][0];

endmodule

// File: rtl/slice_ripple.sv
module slice_ripple
    import slice_pkg::*;
#(
    parameter int W = 2
) (
    input  ripple_op_e     op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [W-1:0]   q,
    input  logic           dyn_sub,
    input  logic           cin,
    output logic [W-1:0]   f,
    output logic           cout
);

    logic [W-1:0] x;
    logic [W-1:0] y;
    logic [W-1:0] gen;
    logic [W-1:0] prop;
    logic [W-1:0] sum;
    logic [W:0]   c;
    logic         ne;

    // operand steering per operation
    always_comb begin
        x = a;
        y = b;
        unique case (op)
            OP_ADD:    begin x = a; y = b;  end
            OP_SUB:    begin x = a; y = ~b; end
            OP_ADDSUB: begin x = a; y = dyn_sub ? ~b : b; end
            OP_UP:     begin x = q; y = '0; end
            OP_DOWN:   begin x = q; y = '1; end
            OP_GE:     begin x = a; y = ~b; end
            OP_LE:     begin x = b; y = ~a; end
            OP_NE:     begin x = a; y = b;  end
            default:   begin x = a; y = b;  end
        endcase
    end

    assign c[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign gen[i]  = x[i] & y[i];
        assign prop[i] = x[i] ^ y[i];
        assign c[i+1]  = gen[i] | (prop[i] & c[i]);
        assign sum[i]  = prop[i] ^ c[i];
    end

    assign ne = cin | (a != b);

    always_comb begin
        unique case (op)
            OP_GE, OP_LE: begin
                f    = {{(W-1){1'b0}}, c[W]};
                cout = c[W];
            end
            OP_NE: begin
                f    = {{(W-1){1'b0}}, ne};
                cout = ne;
            end
            default: begin
                f    = sum;
                cout = c[W];
            end
        endcase
    end

endmodule

// File: rtl/logic_slice.sv
module logic_slice
    import slice_pkg::*;
#(
    parameter bit HAS_RAM = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_addr,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic [LUT_K-1:0]     in0,
    input  logic [LUT_K-1:0]     in1,
    input  logic                 m0,
    input  logic                 m1,
    input  logic                 ce,
    input  logic                 lsr,
    input  logic                 cin,
    output logic                 f0,
    output logic                 f1,
    output logic                 ofx,
    output logic                 q0,
    output logic                 q1,
    output logic                 cout,
    output logic                 cfg_err
);

    localparam logic [1:0] ADDR_TAB0 = 2'd0;
    localparam logic [1:0] ADDR_TAB1 = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    slice_state_t st_d, st_q;

    slice_ctrl_t          ctrl_q;
    logic [LUT_DEPTH-1:0] tab0_q;
    logic [LUT_DEPTH-1:0] tab1_q;

    assign ctrl_q = st_q.ctrl;
    assign tab0_q = st_q.tab0;
    assign tab1_q = st_q.tab1;

    logic ram_sel;
    logic ram_ok;

    assign ram_sel = (ctrl_q.mode == MODE_RAM);
    assign ram_ok  = ram_sel && HAS_RAM;

    // table reads: RAM mode shares one address across both tables
    logic [LUT_DEPTH-1:0] lut_tab [2];
    logic [LUT_K-1:0]     lut_sel [2];
    logic [1:0]           lut_y;

    assign lut_tab[0] = tab0_q;
    assign lut_tab[1] = tab1_q;
    assign lut_sel[0] = in0;
    assign lut_sel[1] = ram_sel ? in0 : in1;

    for (genvar t = 0; t < 2; t++) begin : g_lut
        slice_lut #(.K(LUT_K)) u_lut (
            .tab (lut_tab[t]),
            .sel (lut_sel[t]),
            .y   (lut_y[t])
        );
    end

    // ripple unit
    logic [ARITH_W-1:0] ar_a, ar_b, ar_f;
    logic               ar_cout;

    assign ar_a = {in1[0], in0[0]};
    assign ar_b = {in1[1], in0[1]};

    slice_ripple #(.W(ARITH_W)) u_ripple (
        .op      (ctrl_q.op),
        .a       (ar_a),
        .b       (ar_b),
        .q       ({st_q.q1, st_q.q0}),
        .dyn_sub (m0),
        .cin     (cin),
        .f       (ar_f),
        .cout    (ar_cout)
    );

    always_comb begin
        st_d = st_q;

        // output selection by mode
        f0      = 1'b0;
        f1      = 1'b0;
        ofx     = 1'b0;
        cout    = 1'b0;
        cfg_err = 1'b0;
        unique case (ctrl_q.mode)
            MODE_LOGIC: begin
                f0  = lut_y[0];
                f1  = lut_y[1];
                ofx = m0 ? lut_y[1] : lut_y[0];
            end
            MODE_RIPPLE: begin
                f0   = ar_f[0];
                f1   = ar_f[1];
                cout = ar_cout;
            end
            MODE_RAM: begin
                if (ram_ok) begin
                    f0 = lut_y[0];
                    f1 = lut_y[1];
                end else begin
                    cfg_err = 1'b1;
                end
            end
            MODE_ROM: begin
                f0 = lut_y[0];
                f1 = lut_y[1];
            end
            default: ;
        endcase

        // distributed RAM write
        if (ram_ok && ce) begin
            st_d.tab0[in0] = m0;
            st_d.tab1[in0] = m1;
        end

        // configuration port has the last word
        if (cfg_we) begin
            unique case (cfg_addr)
                ADDR_TAB0: st_d.tab0 = cfg_wdata;
                ADDR_TAB1: st_d.tab1 = cfg_wdata;
                ADDR_CTRL: st_d.ctrl = slice_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
                default:   ;
            endcase
        end

        // output registers: lsr over ce over hold
        if (lsr) begin
            st_d.q0 = ctrl_q.init0;
            st_d.q1 = ctrl_q.init1;
        end else if (ce) begin
            st_d.q0 = ctrl_q.src0 ? m0 : f0;
            st_d.q1 = ctrl_q.src1 ? m1 : f1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q0 = st_q.q0;
    assign q1 = st_q.q1;

endmodule

// File: rtl/slice_chk.sv
module slice_chk
    import slice_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 lsr,
    input logic                 ce,
    input logic                 cfg_we,
    input logic                 f0,
    input logic                 f1,
    input logic                 ofx,
    input logic                 cout,
    input logic                 q0,
    input logic                 q1,
    input logic                 cfg_err,
    input slice_ctrl_t          ctrl,
    input logic [LUT_DEPTH-1:0] tab0,
    input logic [LUT_DEPTH-1:0] tab1
);

    p_cout_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode != MODE_RIPPLE) |-> !cout);

    p_rom_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode == MODE_ROM && !cfg_we) |=> ($stable(tab0) && $stable(tab1)));

    p_ramoff_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!f0 && !f1 && !ofx && !cout && ctrl.mode == MODE_RAM));

    p_lsr_init_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lsr |=> (q0 == $past(ctrl.init0) && q1 == $past(ctrl.init1)));

    p_ce_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!lsr && !ce) |=> ($stable(q0) && $stable(q1)));

endmodule

bind logic_slice slice_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .lsr     (lsr),
    .ce      (ce),
    .cfg_we  (cfg_we),
    .f0      (f0),
    .f1      (f1),
    .ofx     (ofx),
    .cout    (cout),
    .q0      (q0),
    .q1      (q1),
    .cfg_err (cfg_err),
    .ctrl    (ctrl_q),
    .tab0    (tab0_q),
    .tab1    (tab1_q)
);

// File: tb/test_logic_slice.sv
module test_logic_slice;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [3:0]  in0 = '0, in1 = '0;
    logic        m0 = 1'b0, m1 = 1'b0, ce = 1'b0, lsr = 1'b0, cin = 1'b0;
    logic        f0, f1, ofx, q0, q1, cout, cfg_err;
    logic        n_f0, n_f1, n_ofx, n_q0, n_q1, n_cout, n_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    logic_slice #(.HAS_RAM(1'b1)) i_logic_slice (
        .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .in0, .in1, .m0, .m1,
        .ce, .lsr, .cin, .f0, .f1, .ofx, .q0, .q1, .cout, .cfg_err
    );

    logic_slice #(.HAS_RAM(1'b0)) i_logic_slice_noram (
        .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .in0, .in1, .m0, .m1,
        .ce, .lsr, .cin, .f0(n_f0), .f1(n_f1), .ofx(n_ofx), .q0(n_q0),
        .q1(n_q1), .cout(n_cout), .cfg_err(n_err)
    );

    // op, a, b, m0, cin, expected {f1,f0}, expected cout
    localparam logic [11:0] VEC [13] = '{
        {3'd0, 2'd1, 2'd2, 1'b0, 1'b0, 2'd3, 1'b0},
        {3'd0, 2'd3, 2'd3, 1'b0, 1'b1, 2'd3, 1'b1},
        {3'd1, 2'd3, 2'd1, 1'b0, 1'b1, 2'd2, 1'b1},
        {3'd1, 2'd1, 2'd2, 1'b0, 1'b1, 2'd3, 1'b0},
        {3'd2, 2'd2, 2'd1, 1'b0, 1'b0, 2'd3, 1'b0},
        {3'd2, 2'd2, 2'd1, 1'b1, 1'b1, 2'd1, 1'b1},
        {3'd5, 2'd2, 2'd2, 1'b0, 1'b1, 2'd1, 1'b1},
        {3'd5, 2'd1, 2'd2, 1'b0, 1'b1, 2'd0, 1'b0},
        {3'd7, 2'd1, 2'd2, 1'b0, 1'b1, 2'd1, 1'b1},
        {3'd7, 2'd3, 2'd0, 1'b0, 1'b1, 2'd0, 1'b0},
        {3'd6, 2'd1, 2'd2, 1'b0, 1'b0, 2'd1, 1'b1},
        {3'd6, 2'd2, 2'd2, 1'b0, 1'b0, 2'd0, 1'b0},
        {3'd6, 2'd2, 2'd2, 1'b0, 1'b1, 2'd1, 1'b1}
    };

    function automatic logic [15:0] mk_ctrl(input logic [1:0] mode, input logic [2:0] op,
                                            input logic i0, input logic i1,
                                            input logic s0, input logic s1);
        return {7'd0, s1, s0, i1, i0, op, mode};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [1:0] addr, input logic [15:0] data);
        cfg_we    = 1'b1;
        cfg_addr  = addr;
        cfg_wdata = data;
        tick();
        cfg_we    = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 outputs", {f0, f1, ofx, q0, q1, cout, cfg_err}, 7'b0);
        rst_n = 1'b1;
        tick();
        chk("R12 after release", {f0, f1, ofx, q0, q1, cout, cfg_err}, 7'b0);

        // R1/R2/R3 logic mode
        cfg_write(2'd0, 16'h8000);
        cfg_write(2'd1, 16'hFFFE);
        cfg_write(2'd2, mk_ctrl(2'd0, 3'd0, 0, 0, 0, 0));
        in0 = 4'hF; in1 = 4'h0; m0 = 1'b0; #2;
        chk("R2 and/or", {f1, f0}, 2'b01);
        chk("R3 ofx m0=0", ofx, 1'b1);
        m0 = 1'b1; #2;
        chk("R3 ofx m0=1", ofx, 1'b0);
        in0 = 4'hE; in1 = 4'h1; #2;
        chk("R2 second pattern", {f1, f0}, 2'b10);
        chk("R3 ofx sel table1", ofx, 1'b1);
        in0 = 4'hF; in1 = 4'hF; m0 = 1'b0; #2;
        chk("R3 five-input", {ofx, f1, f0}, 3'b111);
        cfg_write(2'd3, 16'h0000);
        #2;
        chk("R1 addr3 ignored", f0, 1'b1);
        chk("R4 cout idle logic", cout, 1'b0);

        // R4/R6 vector table
        for (int i = 0; i < 13; i++) begin
            logic [2:0] op;
            logic [1:0] a, b;
            op = VEC[i][11:9]; a = VEC[i][8:7]; b = VEC[i][6:5];
            cfg_write(2'd2, mk_ctrl(2'd1, op, 0, 0, 0, 0));
            in0 = {2'b00, b[0], a[0]};
            in1 = {2'b00, b[1], a[1]};
            m0  = VEC[i][4];
            cin = VEC[i][3];
            #2;
            chk((op >= 3'd5) ? "R6 compare" : "R4 arith",
                {f1, f0, cout}, {VEC[i][2:1], VEC[i][0]});
        end

        // R5 counters
        cin = 1'b1; ce = 1'b0;
        cfg_write(2'd2, mk_ctrl(2'd1, 3'd3, 0, 0, 0, 0));
        lsr = 1'b1; tick(); lsr = 1'b0;
        ce = 1'b1;
        tick(); chk("R5 up 1", {q1, q0}, 2'd1);
        tick(); chk("R5 up 2", {q1, q0}, 2'd2);
        tick(); chk("R5 up 3", {q1, q0}, 2'd3);
        chk("R5 up carry", cout, 1'b1);
        tick(); chk("R5 up wrap", {q1, q0}, 2'd0);
        ce = 1'b0;
        cfg_write(2'd2, mk_ctrl(2'd1, 3'd4, 0, 0, 0, 0));
        cin = 1'b0; #2;
        chk("R5 down borrow", cout, 1'b0);
        ce = 1'b1;
        tick(); chk("R5 down 3", {q1, q0}, 2'd3);
        tick(); chk("R5 down 2", {q1, q0}, 2'd2);
        cin = 1'b1;
        tick(); chk("R5 down hold cin", {q1, q0}, 2'd2);
        ce = 1'b0;

        // R8 ROM mode
        cfg_write(2'd0, 16'h1234);
        cfg_write(2'd2, mk_ctrl(2'd3, 3'd0, 0, 0, 0, 0));
        in0 = 4'd2; in1 = 4'd1; m0 = 1'b1; #2;
        chk("R8 rom read", {f1, f0}, 2'b11);
        chk("R3 ofx idle rom", ofx, 1'b0);
        in0 = 4'd0; m1 = 1'b1; ce = 1'b1;
        tick(); ce = 1'b0; #2;
        chk("R8 no write", f0, 1'b0);

        // R7 RAM / R9 RAM-less
        cfg_write(2'd0, 16'h0000);
        cfg_write(2'd1, 16'h0000);
        cfg_write(2'd2, mk_ctrl(2'd2, 3'd0, 0, 0, 0, 0));
        in0 = 4'd5; in1 = 4'd6; m0 = 1'b1; m1 = 1'b1; #2;
        chk("R7 before write", {f1, f0}, 2'b00);
        chk("R9 err flag", n_err, 1'b1);
        chk("R12 err clear with ram", cfg_err, 1'b0);
        ce = 1'b1; tick(); ce = 1'b0; #2;
        chk("R7 written", {f1, f0}, 2'b11);
        chk("R9 outputs zero", {n_f1, n_f0, n_ofx, n_cout}, 4'b0);
        in0 = 4'd6; #2;
        chk("R7 async read", {f1, f0}, 2'b00);
        in0 = 4'd5; m0 = 1'b0; m1 = 1'b0; tick(); #2;
        chk("R7 ce low no write", {f1, f0}, 2'b11);
        cfg_write(2'd2, mk_ctrl(2'd3, 3'd0, 0, 0, 0, 0));
        in0 = 4'd5; in1 = 4'd5; #2;
        chk("R7 ram kept", {f1, f0}, 2'b11);
        chk("R9 no write", {n_f1, n_f0}, 2'b00);

        // R10/R11 registers
        cfg_write(2'd1, 16'hFFFE);
        cfg_write(2'd2, mk_ctrl(2'd0, 3'd0, 1, 0, 1, 0));
        lsr = 1'b1; tick(); lsr = 1'b0;
        chk("R10 init load", {q1, q0}, 2'b01);
        m0 = 1'b0; in1 = 4'd1; ce = 1'b1; tick();
        chk("R11 source load", {q1, q0}, 2'b10);
        lsr = 1'b1; tick(); lsr = 1'b0;
        chk("R10 over ce", {q1, q0}, 2'b01);
        ce = 1'b0; m0 = 1'b0; in1 = 4'd1; tick();
        chk("R11 hold", {q1, q0}, 2'b01);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule